// File: doc/BRIEF.md
# Mixed-Width Dual-Clock Dual-Port RAM

This block is an 18,432-bit synchronous memory with two fully independent ports, each on its own clock. The wide port sees the storage as 1024 words of 18 bits: 16 data bits plus 2 parity bits. The narrow port sees the same bits as 2048 words of 9 bits: 8 data bits plus 1 parity bit. Data written through one port at one width can be read through the other port at the other width, so the memory also converts data width with no logic around it.

Each port has an enable, a write enable, a synchronous reset for its output register, an address, write data with parity, and registered read data with parity. The lowest bit of the narrow address picks one half of a wide word. The remaining narrow address bits equal the wide address of that word.

Top module: `mwdp_ram`

## Requirements
- R1: The wide port has a 10-bit address over 1024 words, each with 16 data bits and 2 parity bits. A read at a clock edge presents the stored word on `a_rdata`/`a_rpar` after that edge.
- R2: The narrow port has an 11-bit address over 2048 words, each with 8 data bits and 1 parity bit. A read at a clock edge presents the stored byte on `b_rdata`/`b_rpar` after that edge.
- R3: Narrow address value {W, 0} maps to wide word W, data bits 7:0 and parity bit 0. Narrow address value {W, 1} maps to wide word W, data bits 15:8 and parity bit 1.
- R4: While a port's enable is low, its output register keeps its value and a raised write enable stores nothing.
- R5: When a port's reset and enable are both high at an edge, its output register becomes zero after that edge. The memory contents are not changed by the reset. A write issued in the same cycle still takes place.
- R6: When a port writes an address, its own output shows the new data after that edge (write-first).
- R7: Data written through either port at an edge can be read through the other port from any later edge of that port.
- R8: When both ports write in the same cycle to bits that do not overlap, both writes are kept. When they write the same bits, the stored value is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Wide port clock |
| a_en | input | 1 | Wide port enable |
| a_we | input | 1 | Wide port write enable |
| a_rst | input | 1 | Wide port output register reset, synchronous, active high |
| a_addr | input | 10 | Wide port word address |
| a_wdata | input | 16 | Wide port write data |
| a_wpar | input | 2 | Wide port write parity (bit h goes with byte h) |
| a_rdata | output | 16 | Wide port read data |
| a_rpar | output | 2 | Wide port read parity |
| b_clk | input | 1 | Narrow port clock |
| b_en | input | 1 | Narrow port enable |
| b_we | input | 1 | Narrow port write enable |
| b_rst | input | 1 | Narrow port output register reset, synchronous, active high |
| b_addr | input | 11 | Narrow port byte address |
| b_wdata | input | 8 | Narrow port write data |
| b_wpar | input | 1 | Narrow port write parity |
| b_rdata | output | 8 | Narrow port read data |
| b_rpar | output | 1 | Narrow port read parity |

## Verification
On every edge of its own clock, the assertions check each port's output register: it holds while the port is disabled, it clears after an enabled reset, and it shows the written value after an enabled write. Whether data actually lands in the storage cannot be seen from one port's output in one cycle. The bench scenarios show this: width translation between the ports, read-back after a disabled write or an output reset, and two writes in the same cycle to different halves of a wide word. The bench compares against its own byte-level model and does not check reads that race an opposite-port write to the same bits.

// File: rtl/mwdp_pkg.sv
package mwdp_pkg;

    localparam int BYTE_W   = 8;
    localparam int HALVES   = 2;
    localparam int HALF_W   = BYTE_W + 1;
    localparam int WIDE_DW  = BYTE_W * HALVES;
    localparam int WIDE_W   = HALF_W * HALVES;

    // One narrow word: parity bit above its data byte.
    typedef struct packed {
        logic              par;
        logic [BYTE_W-1:0] data;
    } half_t;

    function automatic half_t make_half(input logic par, input logic [BYTE_W-1:0] data);
        half_t h;
        h.par  = par;
        h.data = data;
        return h;
    endfunction

    // Wide word as seen at the wide port: {parity[1:0], data[15:0]}.
    function automatic logic [WIDE_W-1:0] join_wide(input half_t hi, input half_t lo);
        return {hi.par, lo.par, hi.data, lo.data};
    endfunction

endpackage

// File: rtl/mwdp_half_store.sv
module mwdp_half_store
    import mwdp_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int NRD   = 2
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  half_t                     wr_val,
    input  logic                      wr_flag,
    input  logic [NRD-1:0][IDX_W-1:0] rd_idx,
    output half_t [NRD-1:0]           rd_val,
    output logic [NRD-1:0]            rd_flag
);
    localparam int DEPTH = 1 << IDX_W;

    half_t mem [DEPTH];
    logic  flg [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_val;
            flg[wr_idx] <= wr_flag;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_val[r]  = mem[rd_idx[r]];
        assign rd_flag[r] = flg[rd_idx[r]];
    end
endmodule

// File: rtl/mwdp_out_reg.sv
module mwdp_out_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         en,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] mem_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (en) begin
            if (rst)      q <= '0;
            else if (wr)  q <= wr_val;
            else          q <= mem_val;
        end
    end
endmodule

// File: rtl/mwdp_ram.sv
module mwdp_ram
    import mwdp_pkg::*;
#(
    parameter int ADDR_A_W = 10,
    localparam int ADDR_B_W = ADDR_A_W + 1
) (
    input  logic                a_clk,
    input  logic                a_en,
    input  logic                a_we,
    input  logic                a_rst,
    input  logic [ADDR_A_W-1:0] a_addr,
    input  logic [WIDE_DW-1:0]  a_wdata,
    input  logic [HALVES-1:0]   a_wpar,
    output logic [WIDE_DW-1:0]  a_rdata,
    output logic [HALVES-1:0]   a_rpar,
    input  logic                b_clk,
    input  logic                b_en,
    input  logic                b_we,
    input  logic                b_rst,
    input  logic [ADDR_B_W-1:0] b_addr,
    input  logic [BYTE_W-1:0]   b_wdata,
    input  logic                b_wpar,
    output logic [BYTE_W-1:0]   b_rdata,
    output logic                b_rpar
);
    // Each port owns a private copy; a flag pair per narrow word tells
    // which copy was written last (equal flags: wide copy is newest).
    localparam int A_RD = 2;            // 0: own port, 1: narrow port
    localparam int B_RD = 1 + HALVES;   // 0: own port, 1+h: wide port half h

    logic [ADDR_A_W-1:0] b_word;
    logic                b_sel;
    assign b_word = b_addr[ADDR_B_W-1:1];
    assign b_sel  = b_addr[0];

    half_t [A_RD-1:0] a_rv [HALVES];
    logic  [A_RD-1:0] a_rf [HALVES];
    half_t [B_RD-1:0] b_rv;
    logic  [B_RD-1:0] b_rf;

    half_t a_mem_half [HALVES];
    logic  [B_RD-1:0][ADDR_B_W-1:0] b_idx;

    assign b_idx[0] = b_addr;

    for (genvar h = 0; h < HALVES; h++) begin : g_wide
        logic [A_RD-1:0][ADDR_A_W-1:0] idx;
        assign idx            = {b_word, a_addr};
        assign b_idx[1 + h]   = {a_addr, 1'(h)};

        mwdp_half_store #(.IDX_W(ADDR_A_W), .NRD(A_RD)) u_store (
            .clk     (a_clk),
            .wr_en   (a_en & a_we),
            .wr_idx  (a_addr),
            .wr_val  (make_half(a_wpar[h], a_wdata[h*BYTE_W +: BYTE_W])),
            .wr_flag (b_rf[1 + h]),
            .rd_idx  (idx),
            .rd_val  (a_rv[h]),
            .rd_flag (a_rf[h])
        );

        assign a_mem_half[h] = (a_rf[h][0] == b_rf[1 + h]) ? a_rv[h][0] : b_rv[1 + h];
    end

    mwdp_half_store #(.IDX_W(ADDR_B_W), .NRD(B_RD)) u_narrow_store (
        .clk     (b_clk),
        .wr_en   (b_en & b_we),
        .wr_idx  (b_addr),
        .wr_val  (make_half(b_wpar, b_wdata)),
        .wr_flag (~a_rf[b_sel][1]),
        .rd_idx  (b_idx),
        .rd_val  (b_rv),
        .rd_flag (b_rf)
    );

    half_t b_mem;
    always_comb begin
        b_mem = (a_rf[b_sel][1] == b_rf[0]) ? a_rv[b_sel][1] : b_rv[0];
    end

    logic [WIDE_W-1:0] a_q;
    mwdp_out_reg #(.W(WIDE_W)) u_a_out (
        .clk     (a_clk),
        .en      (a_en),
        .rst     (a_rst),
        .wr      (a_we),
        .wr_val  ({a_wpar, a_wdata}),
        .mem_val (join_wide(a_mem_half[1], a_mem_half[0])),
        .q       (a_q)
    );
    assign {a_rpar, a_rdata} = a_q;

    logic [HALF_W-1:0] b_q;
    mwdp_out_reg #(.W(HALF_W)) u_b_out (
        .clk     (b_clk),
        .en      (b_en),
        .rst     (b_rst),
        .wr      (b_we),
        .wr_val  ({b_wpar, b_wdata}),
        .mem_val (b_mem),
        .q       (b_q)
    );
    assign {b_rpar, b_rdata} = b_q;
endmodule

// File: rtl/mwdp_ram_chk.sv
module mwdp_ram_chk (
    input logic        a_clk,
    input logic        a_en,
    input logic        a_we,
    input logic        a_rst,
    input logic [15:0] a_wdata,
    input logic [1:0]  a_wpar,
    input logic [15:0] a_rdata,
    input logic [1:0]  a_rpar,
    input logic        b_clk,
    input logic        b_en,
    input logic        b_we,
    input logic        b_rst,
    input logic [7:0]  b_wdata,
    input logic        b_wpar,
    input logic [7:0]  b_rdata,
    input logic        b_rpar
);
    logic a_live = 1'b0;
    logic b_live = 1'b0;
    always_ff @(posedge a_clk) a_live <= 1'b1;
    always_ff @(posedge b_clk) b_live <= 1'b1;

    p_hold_a_r4: assert property (@(posedge a_clk) disable iff (!a_live)
        !a_en |=> $stable({a_rpar, a_rdata}));
    p_hold_b_r4: assert property (@(posedge b_clk) disable iff (!b_live)
        !b_en |=> $stable({b_rpar, b_rdata}));
    p_clear_a_r5: assert property (@(posedge a_clk) disable iff (!a_live)
        (a_en && a_rst) |=> ({a_rpar, a_rdata} == '0));
    p_clear_b_r5: assert property (@(posedge b_clk) disable iff (!b_live)
        (b_en && b_rst) |=> ({b_rpar, b_rdata} == '0));
    p_wfirst_a_r6: assert property (@(posedge a_clk) disable iff (!a_live)
        (a_en && a_we && !a_rst) |=> ({a_rpar, a_rdata} == $past({a_wpar, a_wdata})));
    p_wfirst_b_r6: assert property (@(posedge b_clk) disable iff (!b_live)
        (b_en && b_we && !b_rst) |=> ({b_rpar, b_rdata} == $past({b_wpar, b_wdata})));
endmodule

bind mwdp_ram mwdp_ram_chk u_chk (
    .a_clk(a_clk), .a_en(a_en), .a_we(a_we), .a_rst(a_rst),
    .a_wdata(a_wdata), .a_wpar(a_wpar), .a_rdata(a_rdata), .a_rpar(a_rpar),
    .b_clk(b_clk), .b_en(b_en), .b_we(b_we), .b_rst(b_rst),
    .b_wdata(b_wdata), .b_wpar(b_wpar), .b_rdata(b_rdata), .b_rpar(b_rpar)
);

// File: tb/mwdp_ram_tb.sv
`timescale 1ns/1ps
module mwdp_ram_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        a_en = 0, a_we = 0, a_rst = 0;
    logic [9:0]  a_addr = '0;
    logic [15:0] a_wdata = '0;
    logic [1:0]  a_wpar = '0;
    logic [15:0] a_rdata;
    logic [1:0]  a_rpar;
    logic        b_en = 0, b_we = 0, b_rst = 0;
    logic [10:0] b_addr = '0;
    logic [7:0]  b_wdata = '0;
    logic        b_wpar = 0;
    logic [7:0]  b_rdata;
    logic        b_rpar;

    mwdp_ram u_dut (
        .a_clk(clk), .a_en(a_en), .a_we(a_we), .a_rst(a_rst), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_wpar(a_wpar), .a_rdata(a_rdata), .a_rpar(a_rpar),
        .b_clk(clk), .b_en(b_en), .b_we(b_we), .b_rst(b_rst), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_wpar(b_wpar), .b_rdata(b_rdata), .b_rpar(b_rpar)
    );

    // Byte-level model: entry {word, half} holds {parity, data}.
    logic [8:0]  model [2048];
    logic        known [2048];
    logic [17:0] exp_a = '0;
    logic [8:0]  exp_b = '0;
    logic        ok_a = 0, ok_b = 0;
    string       tag_a = "", tag_b = "";
    int          checks = 0, failures = 0, cycles = 0;
    logic        done = 0;

    initial for (int i = 0; i < 2048; i++) known[i] = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic tick();
        string ta, tb;
        // wide port expectation
        if (a_en) begin
            ta = "R1";
            if (a_rst) begin exp_a = '0; ok_a = 1; ta = "R5"; end
            else if (a_we) begin exp_a = {a_wpar, a_wdata}; ok_a = 1; ta = "R6"; end
            else begin
                exp_a = {model[{a_addr,1'b1}][8], model[{a_addr,1'b0}][8],
                         model[{a_addr,1'b1}][7:0], model[{a_addr,1'b0}][7:0]};
                ok_a = known[{a_addr,1'b0}] && known[{a_addr,1'b1}]
                       && !(b_en && b_we && b_addr[10:1] == a_addr);
            end
        end else ta = "R4";
        if (b_en) begin
            tb = "R2";
            if (b_rst) begin exp_b = '0; ok_b = 1; tb = "R5"; end
            else if (b_we) begin exp_b = {b_wpar, b_wdata}; ok_b = 1; tb = "R6"; end
            else begin
                exp_b = model[b_addr];
                ok_b  = known[b_addr] && !(a_en && a_we && a_addr == b_addr[10:1]);
            end
        end else tb = "R4";
        if (tag_a != "") ta = tag_a;
        if (tag_b != "") tb = tag_b;
        if (a_en && a_we) begin
            model[{a_addr,1'b0}] = {a_wpar[0], a_wdata[7:0]};
            model[{a_addr,1'b1}] = {a_wpar[1], a_wdata[15:8]};
            known[{a_addr,1'b0}] = 1; known[{a_addr,1'b1}] = 1;
        end
        if (b_en && b_we) begin
            model[b_addr] = {b_wpar, b_wdata};
            known[b_addr] = 1;
        end
        @(posedge clk);
        @(negedge clk);
        if (ok_a) check(ta, {14'd0, a_rpar, a_rdata}, {14'd0, exp_a});
        if (ok_b) check(tb, {23'd0, b_rpar, b_rdata}, {23'd0, exp_b});
        tag_a = ""; tag_b = "";
    endtask

    task automatic idle();
        a_en = 0; a_we = 0; a_rst = 0; b_en = 0; b_we = 0; b_rst = 0;
    endtask

    task automatic a_op(input logic we, input logic [9:0] ad, input logic [15:0] d, input logic [1:0] p);
        a_en = 1; a_we = we; a_rst = 0; a_addr = ad; a_wdata = d; a_wpar = p;
    endtask

    task automatic b_op(input logic we, input logic [10:0] ad, input logic [7:0] d, input logic p);
        b_en = 1; b_we = we; b_rst = 0; b_addr = ad; b_wdata = d; b_wpar = p;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // reset state of both output registers (R5)
        a_en = 1; a_rst = 1; b_en = 1; b_rst = 1;
        tag_a = "R5"; tag_b = "R5";
        tick();
        idle();
        // fill all wide words
        for (int w = 0; w < 1024; w++) begin
            a_op(1, w[9:0], 16'($urandom), 2'($urandom));
            tick();
        end
        idle();
        // R1 boundary: top wide word
        a_op(1, 10'd1023, 16'hA55A, 2'b10); tick();
        a_op(0, 10'd1023, '0, '0); tag_a = "R1"; tick();
        idle();
        // R3: narrow reads of both halves of word 1023
        b_op(0, 11'd2047, '0, 0); tag_b = "R3"; tick();
        b_op(0, 11'd2046, '0, 0); tag_b = "R3"; tick();
        // R2/R3: narrow writes at the top, wide read-back
        b_op(1, 11'd2046, 8'h3C, 1'b1); tick();
        b_op(1, 11'd2047, 8'hC3, 1'b0); tick();
        b_op(0, 11'd2047, '0, 0); tag_b = "R2"; tick();
        idle();
        a_op(0, 10'd1023, '0, '0); tag_a = "R3"; tick();
        idle();
        // R4: disabled write must not store, output holds
        a_en = 0; a_we = 1; a_addr = 10'd7; a_wdata = 16'hDEAD; a_wpar = 2'b11; tick();
        b_en = 0; b_we = 1; b_addr = 11'd14; b_wdata = 8'h99; b_wpar = 1; tick();
        idle();
        a_op(0, 10'd7, '0, '0); tag_a = "R4"; tick();
        b_op(0, 11'd14, '0, 0); tag_b = "R4"; tick();
        idle();
        // R5: reset clears output, contents survive
        a_op(0, 10'd20, '0, '0); a_rst = 1; tick();
        a_rst = 0; tag_a = "R5"; tick();
        b_op(0, 11'd41, '0, 0); b_rst = 1; tick();
        b_rst = 0; tag_b = "R5"; tick();
        idle();
        // R8: same-cycle writes to disjoint bits both persist
        a_op(1, 10'd5, 16'h1234, 2'b01); b_op(1, 11'd12, 8'h77, 1'b1); tick();
        a_op(1, 10'd6, 16'hBEEF, 2'b10); b_op(1, 11'd11, 8'h42, 1'b0); tick();
        a_op(0, 10'd6, '0, '0); b_op(0, 11'd10, '0, 0); tag_a = "R8"; tag_b = "R8"; tick();
        a_op(0, 10'd5, '0, '0); b_op(0, 11'd12, '0, 0); tag_a = "R8"; tag_b = "R8"; tick();
        idle();
        // R7: write on one port, read on the other at the next edge
        b_op(1, 11'd301, 8'h5E, 1'b1); tick();
        idle(); a_op(0, 10'd150, '0, '0); tag_a = "R7"; tick();
        idle(); a_op(1, 10'd151, 16'hF00D, 2'b01); tick();
        idle(); b_op(0, 11'd302, '0, 0); tag_b = "R7"; tick();
        b_op(0, 11'd303, '0, 0); tag_b = "R7"; tick();
        idle();
        // constrained random traffic over a narrow window to provoke overlap
        for (int n = 0; n < 4000; n++) begin
            a_en = ($urandom % 8) != 0; a_we = $urandom % 2; a_rst = ($urandom % 16) == 0;
            a_addr = 10'($urandom % 16); a_wdata = 16'($urandom); a_wpar = 2'($urandom);
            b_en = ($urandom % 8) != 0; b_we = $urandom % 2; b_rst = ($urandom % 16) == 0;
            b_addr = 11'($urandom % 32); b_wdata = 8'($urandom); b_wpar = 1'($urandom);
            if (a_en && a_we && b_en && b_we && b_addr[10:1] == a_addr) b_we = 0;
            tick();
        end
        idle();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule